// File: doc/BRIEF.md
# Configurable Quadrature Encoder Counter

This block turns two quadrature tracks (A, B) and an index track (C) into a position count. The count is wrapped between a programmable lower and upper bound. The A, B and C inputs, the gate input, the external reset input and the latch input are taken as already synchronized to `clk` and already free of glitches. The block registers each input once and detects edges by comparing the new sample with the stored one.

A write-only configuration port holds three registers:

- Address 0 is the control word. It selects the decode multiplier, the gate behaviour, the reset sources and their edges, reversal of the counting direction, and the latch mode.
- Address 1 is the upper wrap bound.
- Address 2 is the lower wrap bound. The index reset and the external reset also load this value into the count.

A latch stage copies the count into a second register when an edge of the selected polarity arrives on the latch input. A valid flag marks a held value. In one-shot mode the first edge after arming captures the count and later edges are ignored. In continuous mode every qualifying edge overwrites the held value.

Top module: `qenc_counter`

## Requirements
- R1: After synchronous reset, `count_o` = 0, `latch_val_o` = 0, `latch_vld_o` = 0 and `dir_up_o` = 0. The control word resets to 0x444, which means gate mode 1, rising external-reset edge and rising latch edge, with everything else 0. The upper bound resets to all ones and the lower bound to 0.
- R2: With control bits [1:0] = 0 (four-fold), every change of exactly one of A or B counts one step. Stepping through AB = 00, 10, 11, 01 counts up and the reverse order counts down. A change of both tracks in one cycle counts nothing.
- R3: With control bits [1:0] = 1 (single), only a rising edge of A counts. It counts up when B is low and down when B is high.
- R4: With control bits [1:0] = 2 (two-fold), both edges of A count. A step is up when A differs from B after the edge and down otherwise. Value 3 counts nothing.
- R5: Control bits [3:2] select the gate. Value 1 blocks counting while `gate_in` is high. Value 2 blocks counting while `gate_in` is low. Values 0 and 3 ignore `gate_in`.
- R6: With control bit 4 set, a rising edge of C loads the lower bound into the count. With bit 4 clear, C has no effect.
- R7: With control bit 5 set, an edge of `ext_rst_in` loads the lower bound into the count. The edge is rising when bit 6 is 1 and falling when bit 6 is 0. Edges of the other polarity have no effect.
- R8: Control bit 7 set swaps up and down steps in every mode.
- R9: An up step when the count equals the upper bound loads the lower bound. Otherwise an up step adds one.
- R10: A down step when the count equals the lower bound loads the upper bound. Otherwise a down step subtracts one.
- R11: When a step and a reset event fall in the same cycle, the count takes the lower bound.
- R12: With control bit 8 (latch enable) set and bit 9 clear (one-shot), the first qualifying latch edge copies the count held before that clock edge into `latch_val_o` and sets `latch_vld_o`. Further edges leave `latch_val_o` unchanged while `latch_vld_o` is set.
- R13: With bits 8 and 9 set (continuous), every qualifying latch edge overwrites `latch_val_o`. The qualifying edge is rising when bit 10 is 1 and falling when bit 10 is 0.
- R14: While bit 8 is clear, `latch_vld_o` is 0 one clock edge later. `dir_up_o` becomes 1 after each up step and 0 after each down step, and keeps its value on reset events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Register select: 0 control, 1 upper bound, 2 lower bound |
| cfg_wdata | input | CNT_W | Write data |
| enc_a | input | 1 | Track A |
| enc_b | input | 1 | Track B |
| enc_c | input | 1 | Index track C |
| gate_in | input | 1 | Gate level |
| ext_rst_in | input | 1 | External reset input |
| latch_in | input | 1 | Latch trigger input |
| count_o | output | CNT_W | Position count |
| latch_val_o | output | CNT_W | Captured count |
| latch_vld_o | output | 1 | Captured count is held |
| dir_up_o | output | 1 | Direction of the last step |

## Verification
Each input change that is present at a rising clock edge is visible on every output right after that edge. Counting, reset events, latch captures and direction updates therefore all have a latency of one edge. A configuration write acts on the edge after the one that stores it. The bench drives inputs on falling edges. Its reference model consumes the same samples at each rising edge, and both the per-cycle comparison and the directed checks read the outputs on the next falling edge.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

  localparam int CFG_AW = 2;
  localparam logic [CFG_AW-1:0] ADDR_CTRL = 2'd0;
  localparam logic [CFG_AW-1:0] ADDR_HI   = 2'd1;
  localparam logic [CFG_AW-1:0] ADDR_LO   = 2'd2;

  typedef enum logic [1:0] {
    EVAL_X4  = 2'd0,
    EVAL_X1  = 2'd1,
    EVAL_X2  = 2'd2,
    EVAL_OFF = 2'd3
  } eval_mode_e;

  typedef enum logic [1:0] {
    GATE_NONE    = 2'd0,
    GATE_LOCK_HI = 2'd1,
    GATE_LOCK_LO = 2'd2,
    GATE_RSV     = 2'd3
  } gate_mode_e;

  // packed MSB first: eval sits in bits [1:0]
  typedef struct packed {
    logic       latch_rise;
    logic       latch_cont;
    logic       latch_en;
    logic       reverse;
    logic       ext_rise;
    logic       ext_en;
    logic       idx_en;
    gate_mode_e gate;
    eval_mode_e eval;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  localparam ctrl_t CTRL_RST = '{
    latch_rise: 1'b1, latch_cont: 1'b0, latch_en: 1'b0, reverse: 1'b0,
    ext_rise: 1'b1, ext_en: 1'b0, idx_en: 1'b0,
    gate: GATE_LOCK_HI, eval: EVAL_X4
  };

endpackage

// File: rtl/qenc_edge_decode.sv
module qenc_edge_decode
  import qenc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  enc_a,
  input  logic  enc_b,
  input  logic  enc_c,
  input  logic  gate_in,
  input  logic  ext_rst_in,
  input  logic  latch_in,
  input  ctrl_t ctrl,
  output logic  step_up,
  output logic  step_dn,
  output logic  clr_evt,
  output logic  latch_hit
);

  localparam int NSIG = 5;
  localparam int IA = 0, IB = 1, IC = 2, IE = 3, IL = 4;

  logic [NSIG-1:0] cur, prev_q, rise, fall;
  logic            hit, up_raw, gate_lock;

  assign cur = {latch_in, ext_rst_in, enc_c, enc_b, enc_a};

  // prior sample is seeded during reset so no edge appears at release
  always_ff @(posedge clk) begin
    prev_q <= cur;
  end

  generate
    for (genvar i = 0; i < NSIG; i++) begin : g_edge
      assign rise[i] = cur[i] & ~prev_q[i];
      assign fall[i] = ~cur[i] & prev_q[i];
    end
  endgenerate

  always_comb begin
    hit    = 1'b0;
    up_raw = 1'b0;
    unique case (ctrl.eval)
      EVAL_X4: begin
        if ((rise[IA] | fall[IA]) && !(rise[IB] | fall[IB])) begin
          hit    = 1'b1;
          up_raw = enc_a ^ enc_b;
        end else if ((rise[IB] | fall[IB]) && !(rise[IA] | fall[IA])) begin
          hit    = 1'b1;
          up_raw = ~(enc_a ^ enc_b);
        end
      end
      EVAL_X1: begin
        hit    = rise[IA];
        up_raw = ~enc_b;
      end
      EVAL_X2: begin
        hit    = rise[IA] | fall[IA];
        up_raw = enc_a ^ enc_b;
      end
      default: begin
        hit    = 1'b0;
        up_raw = 1'b0;
      end
    endcase
  end

  always_comb begin
    gate_lock = 1'b0;
    if (ctrl.gate == GATE_LOCK_HI) gate_lock = gate_in;
    if (ctrl.gate == GATE_LOCK_LO) gate_lock = ~gate_in;
  end

  assign step_up   = hit & ~gate_lock & (up_raw ^ ctrl.reverse);
  assign step_dn   = hit & ~gate_lock & ~(up_raw ^ ctrl.reverse);
  assign clr_evt   = (ctrl.idx_en & rise[IC]) |
                     (ctrl.ext_en & (ctrl.ext_rise ? rise[IE] : fall[IE]));
  assign latch_hit = ctrl.latch_rise ? rise[IL] : fall[IL];

  logic unused_rst;
  assign unused_rst = rst;

endmodule

// File: rtl/qenc_pos_counter.sv
module qenc_pos_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_up,
  input  logic             step_dn,
  input  logic             clr_evt,
  input  logic [CNT_W-1:0] lim_hi,
  input  logic [CNT_W-1:0] lim_lo,
  output logic [CNT_W-1:0] cnt_q,
  output logic             dir_up_q
);

  localparam logic [CNT_W-1:0] UNIT = {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      dir_up_q <= 1'b0;
    end else if (clr_evt) begin
      cnt_q    <= lim_lo;
    end else if (step_up) begin
      cnt_q    <= (cnt_q == lim_hi) ? lim_lo : cnt_q + UNIT;
      dir_up_q <= 1'b1;
    end else if (step_dn) begin
      cnt_q    <= (cnt_q == lim_lo) ? lim_hi : cnt_q - UNIT;
      dir_up_q <= 1'b0;
    end
  end

endmodule

// File: rtl/qenc_latch_unit.sv
module qenc_latch_unit #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             latch_hit,
  input  logic             latch_en,
  input  logic             latch_cont,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] val_q,
  output logic             vld_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q <= '0;
      vld_q <= 1'b0;
    end else if (!latch_en) begin
      vld_q <= 1'b0;
    end else if (latch_hit && (latch_cont || !vld_q)) begin
      val_q <= cnt;
      vld_q <= 1'b1;
    end
  end

endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
  import qenc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CNT_W-1:0]  cfg_wdata,
  input  logic              enc_a,
  input  logic              enc_b,
  input  logic              enc_c,
  input  logic              gate_in,
  input  logic              ext_rst_in,
  input  logic              latch_in,
  output logic [CNT_W-1:0]  count_o,
  output logic [CNT_W-1:0]  latch_val_o,
  output logic              latch_vld_o,
  output logic              dir_up_o
);

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] lim_hi_q, lim_lo_q;
  logic             step_up, step_dn, clr_evt, latch_hit;
  logic             latch_en_w, latch_cont_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= CTRL_RST;
      lim_hi_q <= '1;
      lim_lo_q <= '0;
    end else if (cfg_wr) begin
      unique case (cfg_addr)
        ADDR_CTRL: ctrl_q   <= ctrl_t'(cfg_wdata[CTRL_W-1:0]);
        ADDR_HI:   lim_hi_q <= cfg_wdata;
        ADDR_LO:   lim_lo_q <= cfg_wdata;
        default:   ;
      endcase
    end
  end

  assign latch_en_w   = ctrl_q.latch_en;
  assign latch_cont_w = ctrl_q.latch_cont;

  qenc_edge_decode u_decode (
    .clk        (clk),
    .rst        (rst),
    .enc_a      (enc_a),
    .enc_b      (enc_b),
    .enc_c      (enc_c),
    .gate_in    (gate_in),
    .ext_rst_in (ext_rst_in),
    .latch_in   (latch_in),
    .ctrl       (ctrl_q),
    .step_up    (step_up),
    .step_dn    (step_dn),
    .clr_evt    (clr_evt),
    .latch_hit  (latch_hit)
  );

  qenc_pos_counter #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst      (rst),
    .step_up  (step_up),
    .step_dn  (step_dn),
    .clr_evt  (clr_evt),
    .lim_hi   (lim_hi_q),
    .lim_lo   (lim_lo_q),
    .cnt_q    (count_o),
    .dir_up_q (dir_up_o)
  );

  qenc_latch_unit #(.CNT_W(CNT_W)) u_latch (
    .clk        (clk),
    .rst        (rst),
    .latch_hit  (latch_hit),
    .latch_en   (latch_en_w),
    .latch_cont (latch_cont_w),
    .cnt        (count_o),
    .val_q      (latch_val_o),
    .vld_q      (latch_vld_o)
  );

endmodule

// File: rtl/qenc_counter_checker.sv
module qenc_counter_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             step_up,
  input logic             step_dn,
  input logic             clr_evt,
  input logic             gate_in,
  input logic [1:0]       gate_mode,
  input logic [CNT_W-1:0] lim_hi,
  input logic [CNT_W-1:0] lim_lo,
  input logic [CNT_W-1:0] count,
  input logic             dir_up,
  input logic             latch_en,
  input logic             latch_cont,
  input logic [CNT_W-1:0] latch_val,
  input logic             latch_vld
);

  logic locked;
  assign locked = (gate_mode == 2'd1 && gate_in) || (gate_mode == 2'd2 && !gate_in);

  assert_clr_loads_low_R11: assert property (@(posedge clk) disable iff (rst)
    clr_evt |=> count == $past(lim_lo));

  assert_wrap_up_R9: assert property (@(posedge clk) disable iff (rst)
    (!clr_evt && step_up && count == lim_hi) |=> count == $past(lim_lo));

  assert_wrap_dn_R10: assert property (@(posedge clk) disable iff (rst)
    (!clr_evt && step_dn && count == lim_lo) |=> count == $past(lim_hi));

  assert_gate_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!clr_evt && locked) |=> $stable(count));

  assert_oneshot_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (latch_vld && latch_en && !latch_cont) |=> $stable(latch_val));

  assert_vld_clear_R14: assert property (@(posedge clk) disable iff (rst)
    !latch_en |=> !latch_vld);

  assert_dir_up_R14: assert property (@(posedge clk) disable iff (rst)
    (step_up && !clr_evt) |=> dir_up);

  assert_step_excl_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({step_up, step_dn}));

endmodule

bind qenc_counter qenc_counter_checker #(.CNT_W(CNT_W)) u_qenc_chk (
  .clk        (clk),
  .rst        (rst),
  .step_up    (step_up),
  .step_dn    (step_dn),
  .clr_evt    (clr_evt),
  .gate_in    (gate_in),
  .gate_mode  (ctrl_q.gate),
  .lim_hi     (lim_hi_q),
  .lim_lo     (lim_lo_q),
  .count      (count_o),
  .dir_up     (dir_up_o),
  .latch_en   (latch_en_w),
  .latch_cont (latch_cont_w),
  .latch_val  (latch_val_o),
  .latch_vld  (latch_vld_o)
);

// File: tb/qenc_counter_bench.sv
module qenc_counter_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic        enc_a = 1'b0, enc_b = 1'b0, enc_c = 1'b0;
  logic        gate_in = 1'b0, ext_rst_in = 1'b0, latch_in = 1'b0;
  logic [31:0] count_o, latch_val_o;
  logic        latch_vld_o, dir_up_o;

  int    checks = 0;
  int    failures = 0;
  bit    run = 1'b0;
  bit    done = 1'b0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  qenc_counter u_qenc_counter (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .enc_a(enc_a), .enc_b(enc_b), .enc_c(enc_c), .gate_in(gate_in),
    .ext_rst_in(ext_rst_in), .latch_in(latch_in),
    .count_o(count_o), .latch_val_o(latch_val_o), .latch_vld_o(latch_vld_o),
    .dir_up_o(dir_up_o)
  );

  // ---------------- reference model ----------------
  logic [31:0] m_cnt, m_val, m_hi, m_lo, m_ctrl;
  logic        m_vld, m_dir;
  logic        pa, pb, pc, pe, pl;

  function automatic int qpos(logic a, logic b);
    return a ? (b ? 2 : 1) : (b ? 3 : 0);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_val = 0; m_vld = 0; m_dir = 0;
      m_hi = 32'hFFFF_FFFF; m_lo = 0; m_ctrl = 32'h444;
    end else begin
      int  d, mode, gm;
      bit  up, dn, lock, clr, lh;
      up = 0; dn = 0;
      mode = int'(m_ctrl[1:0]);
      gm   = int'(m_ctrl[3:2]);
      d = (qpos(enc_a, enc_b) - qpos(pa, pb) + 4) % 4;
      if (mode == 0) begin
        up = (d == 1); dn = (d == 3);
      end else if (mode == 1) begin
        if (enc_a && !pa) begin up = !enc_b; dn = enc_b; end
      end else if (mode == 2) begin
        if (enc_a != pa) begin up = (enc_a != enc_b); dn = (enc_a == enc_b); end
      end
      if (m_ctrl[7]) begin bit t; t = up; up = dn; dn = t; end
      lock = (gm == 1 && gate_in) || (gm == 2 && !gate_in);
      if (lock) begin up = 0; dn = 0; end
      clr = (m_ctrl[4] && enc_c && !pc) ||
            (m_ctrl[5] && (m_ctrl[6] ? (ext_rst_in && !pe) : (!ext_rst_in && pe)));
      lh  = m_ctrl[10] ? (latch_in && !pl) : (!latch_in && pl);
      if (!m_ctrl[8]) m_vld = 0;
      else if (lh && (m_ctrl[9] || !m_vld)) begin m_val = m_cnt; m_vld = 1; end
      if (clr) m_cnt = m_lo;
      else if (up) begin m_dir = 1; m_cnt = (m_cnt == m_hi) ? m_lo : m_cnt + 1; end
      else if (dn) begin m_dir = 0; m_cnt = (m_cnt == m_lo) ? m_hi : m_cnt - 1; end
      if (cfg_wr) begin
        if (cfg_addr == 0) m_ctrl = {21'd0, cfg_wdata[10:0]};
        else if (cfg_addr == 1) m_hi = cfg_wdata;
        else if (cfg_addr == 2) m_lo = cfg_wdata;
      end
    end
    pa = enc_a; pb = enc_b; pc = enc_c; pe = ext_rst_in; pl = latch_in;
  end

  always @(negedge clk) begin
    if (run && !rst) begin
      checks++;
      if (count_o !== m_cnt || latch_val_o !== m_val || latch_vld_o !== m_vld || dir_up_o !== m_dir) begin
        failures++;
        $display("FAIL %s model compare: cnt %h/%h val %h/%h vld %b/%b dir %b/%b",
                 cur_req, count_o, m_cnt, latch_val_o, m_val, latch_vld_o, m_vld, dir_up_o, m_dir);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic cfg(logic [1:0] addr, logic [31:0] data);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = addr; cfg_wdata = data;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic step_now(int dir);
    int p;
    p = (qpos(enc_a, enc_b) + dir + 4) % 4;
    enc_a = (p == 1 || p == 2);
    enc_b = (p == 2 || p == 3);
  endtask

  task automatic steps(int n, int dir);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      step_now(dir);
    end
    settle();
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired in %s", cur_req);
      finish_run();
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    settle();
    run = 1'b1;
    cur_req = "R1";
    chk("R1 count", count_o, 0);
    chk("R1 vld", {31'd0, latch_vld_o}, 0);
    chk("R1 dir", {31'd0, dir_up_o}, 0);

    cur_req = "R5";
    @(negedge clk); gate_in = 1'b1;
    steps(4, 1);
    chk("R5 default gate locks high", count_o, 0);
    @(negedge clk); gate_in = 1'b0;

    cur_req = "R2";
    steps(8, 1);
    chk("R2 x4 up", count_o, 8);
    chk("R2 dir up", {31'd0, dir_up_o}, 1);
    steps(3, -1);
    chk("R2 x4 down", count_o, 5);
    chk("R14 dir down", {31'd0, dir_up_o}, 0);

    cur_req = "R3";
    cfg(0, 32'h441);
    steps(8, 1);
    chk("R3 x1 up", count_o, 7);
    steps(8, -1);
    chk("R3 x1 down", count_o, 5);

    cur_req = "R4";
    cfg(0, 32'h442);
    steps(8, 1);
    chk("R4 x2 up", count_o, 9);

    cur_req = "R8";
    cfg(0, 32'h4C0);
    steps(4, 1);
    chk("R8 reversed", count_o, 5);
    chk("R8 dir", {31'd0, dir_up_o}, 0);

    cur_req = "R5";
    cfg(0, 32'h448);
    steps(4, 1);
    chk("R5 mode2 low locks", count_o, 5);
    @(negedge clk); gate_in = 1'b1;
    steps(4, 1);
    chk("R5 mode2 high counts", count_o, 9);
    cfg(0, 32'h440);
    steps(4, 1);
    chk("R5 mode0 ignores gate", count_o, 13);
    @(negedge clk); gate_in = 1'b0;

    cur_req = "R6";
    cfg(0, 32'h450);
    @(negedge clk); enc_c = 1'b1;
    settle();
    chk("R6 index reset", count_o, 0);
    @(negedge clk); enc_c = 1'b0;
    steps(2, 1);
    cfg(0, 32'h440);
    @(negedge clk); enc_c = 1'b1;
    settle();
    chk("R6 index disabled", count_o, 2);
    @(negedge clk); enc_c = 1'b0;

    cur_req = "R7";
    cfg(0, 32'h460);
    @(negedge clk); ext_rst_in = 1'b1;
    settle();
    chk("R7 rising reset", count_o, 0);
    steps(3, 1);
    @(negedge clk); ext_rst_in = 1'b0;
    settle();
    chk("R7 falling ignored", count_o, 3);
    cfg(0, 32'h420);
    @(negedge clk); ext_rst_in = 1'b1;
    settle();
    chk("R7 rising ignored", count_o, 3);
    @(negedge clk); ext_rst_in = 1'b0;
    settle();
    chk("R7 falling reset", count_o, 0);

    cur_req = "R10";
    steps(1, -1);
    chk("R10 wrap to default upper", count_o, 32'hFFFF_FFFF);
    cur_req = "R9";
    steps(1, 1);
    chk("R9 wrap to default lower", count_o, 0);

    cfg(1, 32'd5);
    cfg(2, 32'd2);
    cfg(0, 32'h450);
    @(negedge clk); enc_c = 1'b1;
    settle();
    chk("R6 loads lower bound", count_o, 2);
    @(negedge clk); enc_c = 1'b0;
    steps(3, 1);
    chk("R9 reach upper", count_o, 5);
    steps(1, 1);
    chk("R9 wrap up", count_o, 2);
    cur_req = "R10";
    steps(1, -1);
    chk("R10 wrap down", count_o, 5);

    cur_req = "R11";
    @(negedge clk); step_now(1); enc_c = 1'b1;
    settle();
    chk("R11 reset wins", count_o, 2);
    @(negedge clk); enc_c = 1'b0;
    cfg(1, 32'hFFFF_FFFF);
    cfg(2, 32'd0);

    cur_req = "R12";
    cfg(0, 32'h540);
    @(negedge clk); latch_in = 1'b1;
    settle();
    chk("R12 first capture", latch_val_o, 2);
    chk("R12 valid", {31'd0, latch_vld_o}, 1);
    @(negedge clk); latch_in = 1'b0;
    steps(2, 1);
    @(negedge clk); latch_in = 1'b1;
    settle();
    chk("R12 later edge ignored", latch_val_o, 2);
    @(negedge clk); latch_in = 1'b0;

    cur_req = "R13";
    cfg(0, 32'h740);
    @(negedge clk); latch_in = 1'b1;
    settle();
    chk("R13 continuous capture", latch_val_o, 4);
    @(negedge clk); latch_in = 1'b0;
    steps(1, 1);
    @(negedge clk); latch_in = 1'b1;
    settle();
    chk("R13 overwrite", latch_val_o, 5);
    @(negedge clk); latch_in = 1'b0;
    settle();
    cfg(0, 32'h340);
    steps(1, 1);
    @(negedge clk); latch_in = 1'b1;
    settle();
    chk("R13 rising ignored in falling mode", latch_val_o, 5);
    @(negedge clk); latch_in = 1'b0;
    settle();
    chk("R13 falling capture", latch_val_o, 6);

    cur_req = "R14";
    cfg(0, 32'h040);
    settle();
    chk("R14 valid cleared", {31'd0, latch_vld_o}, 0);
    cfg(0, 32'h540);
    @(negedge clk); latch_in = 1'b1;
    settle();
    chk("R14 rearmed capture", latch_val_o, 6);
    chk("R14 rearmed valid", {31'd0, latch_vld_o}, 1);
    @(negedge clk); latch_in = 1'b0;
    settle();

    done = 1'b1;
    finish_run();
  end

endmodule